// File: doc/BRIEF.md
# Shared Interrupt State Register Bank

This block keeps the per-interrupt state for the shared interrupts of an interrupt distributor. The state is an enable bit, a pending bit, an active bit, a group bit, a trigger-mode bit, a stored input level and a 2-bit non-secure access field. Interrupts 0 to 31 form the private range and have no storage here. Shared interrupts run from 32 up to `NUM_IRQ - 1`. Software reaches the state through a simple word-wide register bus that carries a read strobe, a write strobe, an address, write data and a secure attribute. Writes take effect at the next clock edge. Read data is registered and appears with `bus_rvalid` one cycle after the read strobe.

Every access is filtered bit by bit before it reads or changes any state. A non-secure access made while `sec_off` is low sees only those interrupts that are in the non-secure group. For some windows it also sees interrupts whose access field grants enough rights. Enable, pending and active bits use separate set and clear windows. A write to a set window ORs in the filtered data. A write to a clear window removes the filtered data. Pending reads also show level-sensitive lines that are asserted. A rising edge on an edge-triggered line latches the pending bit.

A single bus state machine produces the response. It has two states. `BS_IDLE` means no read data is presented. `BS_RESP` presents registered read data for one cycle. A read strobe in either state moves to `BS_RESP`. No strobe returns the machine to `BS_IDLE`.

Top module: `sirq_bank`

## Requirements
- R1: `bus_addr` is `{region[3:0], index}`. Bitmap regions take the group number from `index`, so interrupt = 32*index + bit. An access to group 0 (the private range), or to any group at or beyond `NUM_IRQ/32`, reads zero and changes nothing.
- R2: The region codes are: 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 trigger, 8 access field. Bit n of a bitmap word is interrupt 32*index+n. A set-window write ORs in the filtered data. A clear-window write ANDs the bitmap with the inverse of the filtered data. Both windows of a pair read the same bitmap.
- R3: A non-secure access with `sec_off` low may use a bit only when its group bit is 1 (non-secure) for the enable windows, for active writes and for trigger accesses. All other accesses may use every bit.
- R4: For a non-secure access with `sec_off` low, pending-set reads and writes also allow a group-0 interrupt whose access field is 1, 2 or 3. Pending-clear writes, pending-clear reads and active reads allow a group-0 interrupt only when its field is 2 or 3.
- R5: A pending read returns stored pending OR (stored level AND NOT edge-triggered), after filtering.
- R6: A 0-to-1 change on an edge-triggered line sets its pending bit at the next edge. If a pending-clear write hits the same bit in the same cycle, the line change wins. A level-triggered line, or a line that does not change, stores nothing.
- R7: Trigger words hold 16 interrupts each: index h covers interrupts 16h to 16h+15. Bit 2k+1 is the edge flag of interrupt 16h+k, and bit 2k reads as 0. Only bits that pass the R3 filter can be read as 1 or written.
- R8: The group register is usable when `bus_secure` or `sec_off` is high. The access-field register is usable only when `bus_secure` is high and `sec_off` is low. Any other access reads zero and changes nothing.
- R9: An access-field word at index h holds bits [2k+1:2k] = field of interrupt 16h+k.
- R10: `bus_rvalid` is high in exactly the cycle after a read strobe, with `bus_rdata` valid then. A read strobed in the cycle after a write sees that write.
- R11: After reset all stored state is zero and `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Region code and word index |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure |
| sec_off | input | 1 | Security filtering disabled |
| irq_line | input | NUM_IRQ-32 | Input levels; bit i is interrupt 32+i |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is one where three things hold at once for a single group-0 interrupt: a non-secure access, a given access-field value, and one of the two pending thresholds. The bench first sets, through secure writes, three neighbouring group-0 interrupts to field values 1, 2 and 3. It then makes non-secure set and clear accesses across the whole word. Comparing what survives separates the two thresholds. Edge latching is separated from level folding by raising one edge line and one level line together. Both lines are then dropped and one is raised again while its pending bit is cleared.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int WB = 32;

    localparam logic [3:0] RG_GROUP = 4'd0;
    localparam logic [3:0] RG_ENSET = 4'd1;
    localparam logic [3:0] RG_ENCLR = 4'd2;
    localparam logic [3:0] RG_PDSET = 4'd3;
    localparam logic [3:0] RG_PDCLR = 4'd4;
    localparam logic [3:0] RG_ACSET = 4'd5;
    localparam logic [3:0] RG_ACCLR = 4'd6;
    localparam logic [3:0] RG_TRIG  = 4'd7;
    localparam logic [3:0] RG_NSACC = 4'd8;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RESP = 1'b1
    } bus_state_e;

    // Regions addressed in 16-interrupt half words
    function automatic logic is_half(input logic [3:0] r);
        return (r == RG_TRIG) || (r == RG_NSACC);
    endfunction

    // Place 16 edge flags on the odd bits of a word
    function automatic logic [31:0] spread_odd(input logic [15:0] e);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 16; k++) begin
            w[2*k+1] = e[k];
        end
        return w;
    endfunction

    // Collect the odd bits of a word
    function automatic logic [15:0] gather_odd(input logic [31:0] w);
        logic [15:0] e;
        for (int k = 0; k < 16; k++) begin
            e[k] = w[2*k+1];
        end
        return e;
    endfunction

endpackage

// File: rtl/sirq_filter.sv
module sirq_filter
    import sirq_pkg::*;
(
    input  logic [WB-1:0]   gp,
    input  logic [2*WB-1:0] acc,
    input  logic            secure,
    input  logic            sec_off,
    output logic [WB-1:0]   m_grp,
    output logic [WB-1:0]   m_ge1,
    output logic [WB-1:0]   m_ge2
);
    logic restrict_ns;
    logic [WB-1:0] ge1;
    logic [WB-1:0] ge2;

    assign restrict_ns = !secure && !sec_off;

    for (genvar i = 0; i < WB; i++) begin : g_field
        assign ge1[i] = acc[2*i] | acc[2*i+1];
        assign ge2[i] = acc[2*i+1];
    end

    assign m_grp = restrict_ns ? gp         : '1;
    assign m_ge1 = restrict_ns ? (gp | ge1) : '1;
    assign m_ge2 = restrict_ns ? (gp | ge2) : '1;
endmodule

// File: rtl/sirq_word.sv
module sirq_word
    import sirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    region,
    input  logic          half,
    input  logic [WB-1:0] wdata,
    input  logic          secure,
    input  logic          sec_off,
    input  logic [WB-1:0] line,
    output logic [WB-1:0] rword
);
    logic [WB-1:0]   en, pd, ac, gp, eg, lv;
    logic [2*WB-1:0] acc;
    logic [WB-1:0]   en_n, pd_n, ac_n, gp_n, eg_n;
    logic [2*WB-1:0] acc_n;
    logic [WB-1:0]   m_grp, m_ge1, m_ge2;
    logic [WB-1:0]   rise;
    logic [WB-1:0]   pend_view;
    logic [WB-1:0]   eg_vis;
    logic [15:0]     tmask;
    logic [15:0]     tbits;
    logic            grp_ok;
    logic            acc_ok;

    sirq_filter u_filter (
        .gp      (gp),
        .acc     (acc),
        .secure  (secure),
        .sec_off (sec_off),
        .m_grp   (m_grp),
        .m_ge1   (m_ge1),
        .m_ge2   (m_ge2)
    );

    assign grp_ok    = secure || sec_off;
    assign acc_ok    = secure && !sec_off;
    assign rise      = line & ~lv & eg;
    assign pend_view = pd | (lv & ~eg);
    assign eg_vis    = eg & m_grp;
    assign tmask     = half ? m_grp[31:16] : m_grp[15:0];
    assign tbits     = gather_odd(wdata);

    // Next-state for all bitmaps
    always_comb begin
        en_n  = en;
        pd_n  = pd;
        ac_n  = ac;
        gp_n  = gp;
        eg_n  = eg;
        acc_n = acc;
        if (we) begin
            unique case (region)
                RG_GROUP: if (grp_ok) gp_n = wdata;
                RG_ENSET: en_n = en | (wdata & m_grp);
                RG_ENCLR: en_n = en & ~(wdata & m_grp);
                RG_PDSET: pd_n = pd | (wdata & m_ge1);
                RG_PDCLR: pd_n = pd & ~(wdata & m_ge2);
                RG_ACSET: ac_n = ac | (wdata & m_grp);
                RG_ACCLR: ac_n = ac & ~(wdata & m_grp);
                RG_TRIG: begin
                    if (half) eg_n[31:16] = (eg[31:16] & ~tmask) | (tbits & tmask);
                    else      eg_n[15:0]  = (eg[15:0]  & ~tmask) | (tbits & tmask);
                end
                RG_NSACC: begin
                    if (acc_ok) begin
                        if (half) acc_n[63:32] = wdata;
                        else      acc_n[31:0]  = wdata;
                    end
                end
                default: ;
            endcase
        end
        pd_n = pd_n | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            pd  <= '0;
            ac  <= '0;
            gp  <= '0;
            eg  <= '0;
            acc <= '0;
            lv  <= '0;
        end else begin
            en  <= en_n;
            pd  <= pd_n;
            ac  <= ac_n;
            gp  <= gp_n;
            eg  <= eg_n;
            acc <= acc_n;
            lv  <= line;
        end
    end

    // Filtered read view
    always_comb begin
        unique case (region)
            RG_GROUP: rword = grp_ok ? gp : '0;
            RG_ENSET, RG_ENCLR: rword = en & m_grp;
            RG_PDSET: rword = pend_view & m_ge1;
            RG_PDCLR: rword = pend_view & m_ge2;
            RG_ACSET, RG_ACCLR: rword = ac & m_ge2;
            RG_TRIG:  rword = spread_odd(half ? eg_vis[31:16] : eg_vis[15:0]);
            RG_NSACC: rword = acc_ok ? (half ? acc[63:32] : acc[31:0]) : '0;
            default:  rword = '0;
        endcase
    end

    a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en));

    a_r3_ns_enable_set_group_only: assert property (@(posedge clk) disable iff (!rst_n)
        (we && region == RG_ENSET && !secure && !sec_off)
        |=> ((en & ~$past(en) & ~$past(gp)) == '0));

    a_r6_edge_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pd & $past(rise)) == $past(rise)));

    a_r8_field_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(secure && !sec_off)) |=> $stable(acc));
endmodule

// File: rtl/sirq_bus_fsm.sv
module sirq_bus_fsm
    import sirq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [WB-1:0] rsel,
    output logic [WB-1:0] rdata,
    output logic          rvalid
);
    bus_state_e    state_q, state_d;
    logic [WB-1:0] rdata_q;

    always_comb begin
        unique case (state_q)
            BS_IDLE: state_d = rd ? BS_RESP : BS_IDLE;
            BS_RESP: state_d = rd ? BS_RESP : BS_IDLE;
            default: state_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd) rdata_q <= rsel;
        end
    end

    always_comb begin
        rvalid = (state_q == BS_RESP);
        rdata  = rdata_q;
    end

    a_r10_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    a_r10_no_resp_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
endmodule

// File: rtl/sirq_bank.sv
module sirq_bank
    import sirq_pkg::*;
#(
    parameter  int NUM_IRQ = 96,
    localparam int NGRP    = NUM_IRQ / 32,
    localparam int NSG     = NGRP - 1,
    localparam int NSH     = NUM_IRQ - 32,
    localparam int IDX_W   = $clog2(2 * NGRP),
    localparam int ADDR_W  = 4 + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_secure,
    input  logic              sec_off,
    input  logic [NSH-1:0]    irq_line,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);
    logic [3:0]       region;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] gsel;
    logic             half;
    logic             in_range;
    logic [NSG-1:0]   hit;
    logic [WB-1:0]    rword [NSG];
    logic [WB-1:0]    rsel;

    assign region   = bus_addr[ADDR_W-1 -: 4];
    assign idx      = bus_addr[IDX_W-1:0];
    assign gsel     = is_half(region) ? {1'b0, idx[IDX_W-1:1]} : idx;
    assign half     = is_half(region) & idx[0];
    assign in_range = (gsel != '0) && (gsel < IDX_W'(NGRP));

    for (genvar g = 0; g < NSG; g++) begin : g_word
        assign hit[g] = in_range && (gsel == IDX_W'(g + 1));

        sirq_word u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bus_wr && hit[g]),
            .region  (region),
            .half    (half),
            .wdata   (bus_wdata),
            .secure  (bus_secure),
            .sec_off (sec_off),
            .line    (irq_line[g*WB +: WB]),
            .rword   (rword[g])
        );
    end

    always_comb begin
        rsel = '0;
        for (int g = 0; g < NSG; g++) begin
            rsel = rsel | (rword[g] & {WB{hit[g]}});
        end
    end

    sirq_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (bus_rd),
        .rsel   (rsel),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );
endmodule

// File: tb/sirq_bank_test.sv
module sirq_bank_test;
    import sirq_pkg::*;

    localparam int NUM_IRQ = 96;
    localparam int NSH     = NUM_IRQ - 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [6:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic           bus_secure = 1'b1;
    logic           sec_off = 1'b0;
    logic [NSH-1:0] irq_line = '0;
    logic [31:0]    bus_rdata;
    logic           bus_rvalid;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];
    bit          done = 1'b0;

    sirq_bank #(.NUM_IRQ(NUM_IRQ)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .sec_off(sec_off), .irq_line(irq_line),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    always #5 clk = ~clk;

    function automatic logic [6:0] ad(input logic [3:0] r, input logic [2:0] i);
        return {r, i};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = s;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] a, input logic s,
                           input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_secure = s;
        exp_q.push_back(e);
        req_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Monitor: pops expected items as responses arrive
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected response", 32'h1, 32'h0);
                end else begin
                    check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
        do_read(ad(RG_ENSET, 1), 1, 32'h0, "R11 enable reset");
        do_read(ad(RG_PDSET, 2), 1, 32'h0, "R11 pending reset");

        // R2 set and clear windows, write then immediate read (R10)
        do_write(ad(RG_ENSET, 1), 32'hF0F0_00FF, 1);
        do_read(ad(RG_ENSET, 1), 1, 32'hF0F0_00FF, "R2 R10 set window");
        do_write(ad(RG_ENCLR, 1), 32'h0000_000F, 1);
        do_read(ad(RG_ENSET, 1), 1, 32'hF0F0_00F0, "R2 clear window");
        do_read(ad(RG_ENCLR, 1), 1, 32'hF0F0_00F0, "R2 clear window reads bitmap");

        // R1 out of range
        do_write(ad(RG_ENSET, 0), 32'hFFFF_FFFF, 1);
        do_read(ad(RG_ENSET, 0), 1, 32'h0, "R1 private group");
        do_write(ad(RG_ENSET, 3), 32'hFFFF_FFFF, 1);
        do_read(ad(RG_ENSET, 3), 1, 32'h0, "R1 beyond count");
        do_read(ad(RG_ENSET, 1), 1, 32'hF0F0_00F0, "R1 no spill");
        do_read(ad(RG_TRIG, 0), 1, 32'h0, "R1 private trigger");

        // R8 group register
        do_write(ad(RG_GROUP, 1), 32'h0000_FFFF, 1);
        do_read(ad(RG_GROUP, 1), 1, 32'h0000_FFFF, "R8 secure group");
        do_read(ad(RG_GROUP, 1), 0, 32'h0, "R8 ns group hidden");
        do_write(ad(RG_GROUP, 1), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_GROUP, 1), 1, 32'h0000_FFFF, "R8 ns group write ignored");

        // R3 non-secure enable
        do_write(ad(RG_ENSET, 1), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_ENSET, 1), 0, 32'h0000_FFFF, "R3 ns enable view");
        do_read(ad(RG_ENSET, 1), 1, 32'hF0F0_FFFF, "R3 ns enable set masked");

        // R9 access field: irq48=1, irq49=2, irq50=3
        do_write(ad(RG_NSACC, 3), 32'h0000_0039, 1);
        do_read(ad(RG_NSACC, 3), 1, 32'h0000_0039, "R9 field readback");
        do_read(ad(RG_NSACC, 3), 0, 32'h0, "R8 ns field hidden");
        do_write(ad(RG_NSACC, 3), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_NSACC, 3), 1, 32'h0000_0039, "R8 ns field write ignored");

        // R4 pending thresholds
        do_write(ad(RG_PDSET, 1), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_PDSET, 1), 1, 32'h0007_FFFF, "R4 ns pending set threshold");
        do_read(ad(RG_PDCLR, 1), 0, 32'h0006_FFFF, "R4 ns pending clear view");
        do_read(ad(RG_PDSET, 1), 0, 32'h0007_FFFF, "R4 ns pending set view");
        do_write(ad(RG_PDCLR, 1), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_PDSET, 1), 1, 32'h0001_0000, "R4 ns pending clear threshold");

        // R3 active writes, R4 active reads
        do_write(ad(RG_ACSET, 1), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_ACSET, 1), 1, 32'h0000_FFFF, "R3 ns active set masked");
        do_write(ad(RG_ACSET, 1), 32'h0007_0000, 1);
        do_read(ad(RG_ACCLR, 1), 0, 32'h0006_FFFF, "R4 ns active view");

        // R7 trigger, R5 fold, R6 edge latch
        do_write(ad(RG_TRIG, 4), 32'h0000_000F, 1);
        do_read(ad(RG_TRIG, 4), 1, 32'h0000_000A, "R7 odd bits only");
        @(negedge clk);
        irq_line[32] = 1'b1;
        irq_line[34] = 1'b1;
        @(negedge clk);
        do_read(ad(RG_PDSET, 2), 1, 32'h0000_0005, "R5 R6 edge and level");
        @(negedge clk);
        irq_line[32] = 1'b0;
        irq_line[34] = 1'b0;
        @(negedge clk);
        do_read(ad(RG_PDSET, 2), 1, 32'h0000_0001, "R5 R6 level drop");
        @(negedge clk);
        irq_line[32] = 1'b1;
        @(negedge clk);
        do_write(ad(RG_PDCLR, 2), 32'h0000_0001, 1);
        do_read(ad(RG_PDSET, 2), 1, 32'h0, "R6 steady line no relatch");

        // R7 non-secure trigger filtering
        do_write(ad(RG_TRIG, 2), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_TRIG, 2), 1, 32'hAAAA_AAAA, "R7 ns trigger write group1");
        do_write(ad(RG_TRIG, 3), 32'hFFFF_FFFF, 0);
        do_read(ad(RG_TRIG, 3), 1, 32'h0, "R7 ns trigger write group0 ignored");
        do_read(ad(RG_TRIG, 4), 0, 32'h0, "R7 ns trigger read hidden");

        // Security disabled
        @(negedge clk);
        sec_off = 1'b1;
        do_read(ad(RG_GROUP, 1), 0, 32'h0000_FFFF, "R8 group open when disabled");
        do_read(ad(RG_NSACC, 3), 0, 32'h0, "R8 field closed when disabled");
        do_read(ad(RG_ENSET, 1), 0, 32'hF0F0_FFFF, "R3 unmasked when disabled");

        repeat (3) @(negedge clk);
        check("R10 responses outstanding", exp_q.size(), 32'h0);
        check("R10 idle rvalid", {31'b0, bus_rvalid}, 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule